// File: doc/BRIEF.md
# Dual-Tone Divider Generator

This block produces the two square-wave tones of a touch-tone pair from a 4-bit key code. The only time base is a reference clock of nominally 3.579545 MHz. A low-group (row) tone and a high-group (column) tone each come from an integer divider. The divide ratio of each divider depends on the code. A signed digital sample adds the two tones, and the column tone gets the larger amplitude. This pre-emphasis puts the high group about 2.7 dB above the low group, and a later digital-to-analog stage can use the sample directly.

The block samples the code on the cycle where the tone enable goes high and holds it for the whole enabled interval. A controller can therefore change the code input while a tone is still sounding. When the enable is low, both dividers are held at zero phase, both tone bits are low and the sample stays at its idle level.

Top module: `dtmf_pair_gen`

## Requirements
- R1: In synchronous reset (`rst` high at a clock edge) both tone bits read 0 and `sample` reads -114 from that edge on.
- R2: The stored code picks the row tone: codes 1, 2, 3 give 697 Hz; 4, 5, 6 give 770 Hz; 7, 8, 9 give 852 Hz; 10, 11, 12 give 941 Hz; and codes 13, 14, 15 and 0 give 697, 770, 852 and 941 Hz respectively.
- R3: The stored code picks the column tone: codes 1, 4, 7, 11 give 1209 Hz; codes 2, 5, 8, 10 give 1336 Hz; codes 3, 6, 9, 12 give 1477 Hz; codes 13, 14, 15, 0 give 1633 Hz.
- R4: The full divide ratios of the row tones are 5104 (697 Hz), 4640 (770 Hz), 4176 (852 Hz) and 3828 (941 Hz). `low_tone` toggles every half ratio in reference cycles.
- R5: The full divide ratios of the column tones are 2944 (1209 Hz), 2688 (1336 Hz), 2432 (1477 Hz) and 2176 (1633 Hz). `high_tone` toggles every half ratio in reference cycles.
- R6: A start is a clock edge at which `tone_en` is 1 and was 0 at the edge before. At a start both tone bits are 0. Counting edges after the start as n = 0, 1, 2, …, a tone of half ratio H reads ((n / H) mod 2) once n edges have passed.
- R7: The block captures `code` only at a start. Changes to `code` while `tone_en` stays high leave both tones unchanged.
- R8: One edge after `tone_en` is seen low, both tone bits are 0 and `sample` is -114. Both stay there while `tone_en` is low.
- R9: `sample` equals (+48 if `low_tone` else -48) plus (+66 if `high_tone` else -66), in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 3.579545 MHz |
| rst | input | 1 | Synchronous active-high reset |
| tone_en | input | 1 | High to sound the pair; a rising level stores the code |
| code | input | 4 | Key code selecting the tone pair |
| low_tone | output | 1 | Row-group square wave |
| high_tone | output | 1 | Column-group square wave |
| sample | output | 8 | Signed weighted sum of both tones |

## Verification
All sixteen codes are run for longer than a full row period, which covers every row and column ratio. Each pair therefore shows both its first toggle at the half ratio and later toggles. A wrong entry in the code map then shows up apart from a wrong ratio. Random runs use random lengths and random disabled gaps. Some of them change the code halfway through an enabled interval. These runs separate a block that latches the code only at the rising enable from one that follows the live input. They also show whether the dividers really restart from zero phase each time. Checks during the gaps and at reset catch an idle level or a stop behaviour that is wrong. The sample is compared every cycle against the weighted sum, so a swapped or wrong amplitude shows up.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int ROW_RATIO_MAX = 5104;
    localparam int CNT_W         = $clog2(ROW_RATIO_MAX / 2);

    typedef logic [CNT_W-1:0] half_t;

    typedef enum logic [1:0] {
        ROW_697 = 2'd0,
        ROW_770 = 2'd1,
        ROW_852 = 2'd2,
        ROW_941 = 2'd3
    } row_e;

    typedef enum logic [1:0] {
        COL_1209 = 2'd0,
        COL_1336 = 2'd1,
        COL_1477 = 2'd2,
        COL_1633 = 2'd3
    } col_e;

    typedef struct packed {
        row_e row;
        col_e col;
    } pair_t;

    function automatic half_t row_half(input row_e r);
        case (r)
            ROW_697: return half_t'(5104 / 2);
            ROW_770: return half_t'(4640 / 2);
            ROW_852: return half_t'(4176 / 2);
            default: return half_t'(3828 / 2);
        endcase
    endfunction

    function automatic half_t col_half(input col_e c);
        case (c)
            COL_1209: return half_t'(2944 / 2);
            COL_1336: return half_t'(2688 / 2);
            COL_1477: return half_t'(2432 / 2);
            default:  return half_t'(2176 / 2);
        endcase
    endfunction

    function automatic pair_t map_code(input logic [3:0] c);
        pair_t p;
        case (c)
            4'd1:    p = '{ROW_697, COL_1209};
            4'd2:    p = '{ROW_697, COL_1336};
            4'd3:    p = '{ROW_697, COL_1477};
            4'd4:    p = '{ROW_770, COL_1209};
            4'd5:    p = '{ROW_770, COL_1336};
            4'd6:    p = '{ROW_770, COL_1477};
            4'd7:    p = '{ROW_852, COL_1209};
            4'd8:    p = '{ROW_852, COL_1336};
            4'd9:    p = '{ROW_852, COL_1477};
            4'd10:   p = '{ROW_941, COL_1336};
            4'd11:   p = '{ROW_941, COL_1209};
            4'd12:   p = '{ROW_941, COL_1477};
            4'd13:   p = '{ROW_697, COL_1633};
            4'd14:   p = '{ROW_770, COL_1633};
            4'd15:   p = '{ROW_852, COL_1633};
            default: p = '{ROW_941, COL_1633};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map
    import dtmf_pkg::*;
(
    input  logic [3:0] code_q,
    output half_t      row_half_val,
    output half_t      col_half_val
);

    pair_t pair;

    always_comb begin
        pair         = map_code(code_q);
        row_half_val = row_half(pair.row);
        col_half_val = col_half(pair.col);
    end

endmodule

// File: rtl/dtmf_divider.sv
module dtmf_divider
    import dtmf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  run,
    input  half_t half_val,
    output logic  tone
);

    half_t cnt_q;
    logic  tone_q;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt_q  <= '0;
            tone_q <= 1'b0;
        end else if (cnt_q == half_val - 1'b1) begin
            cnt_q  <= '0;
            tone_q <= ~tone_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign tone = tone_q;

    // R4 and R5: a running toggle only ever follows the last count of the half period
    assert_toggle_period_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(clear) && !$past(rst) && !$stable(tone_q))
        |-> ($past(cnt_q) == $past(half_val) - 1'b1));

    // R8: a stopped divider reads low one edge later
    assert_stop_low_R8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tone_q);

    // R6: a start forces zero phase
    assert_start_phase_R6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!tone_q && cnt_q == '0));

endmodule

// File: rtl/dtmf_summer.sv
module dtmf_summer #(
    parameter int LOW_AMP  = 48,
    parameter int HIGH_AMP = 66,
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       low_tone,
    input  logic                       high_tone,
    output logic signed [SAMPLE_W-1:0] sample
);

    localparam logic signed [SAMPLE_W-1:0] LOW_S  = SAMPLE_W'(LOW_AMP);
    localparam logic signed [SAMPLE_W-1:0] HIGH_S = SAMPLE_W'(HIGH_AMP);

    logic signed [SAMPLE_W-1:0] low_part;
    logic signed [SAMPLE_W-1:0] high_part;

    always_comb begin
        low_part  = low_tone  ? LOW_S  : -LOW_S;
        high_part = high_tone ? HIGH_S : -HIGH_S;
        sample    = low_part + high_part;
    end

    // R9: the emphasised column term always sets the sign of the sum
    assert_sign_follows_high_R9: assert property (@(posedge clk) disable iff (rst)
        high_tone ? (sample > 0) : (sample < 0));

endmodule

// File: rtl/dtmf_pair_gen.sv
module dtmf_pair_gen
    import dtmf_pkg::*;
#(
    parameter int LOW_AMP  = 48,
    parameter int HIGH_AMP = 66,
    parameter int SAMPLE_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tone_en,
    input  logic [3:0]                 code,
    output logic                       low_tone,
    output logic                       high_tone,
    output logic signed [SAMPLE_W-1:0] sample
);

    localparam int NUM_GROUPS = 2;
    localparam logic signed [SAMPLE_W-1:0] IDLE_LEVEL = SAMPLE_W'(-(LOW_AMP + HIGH_AMP));

    logic       en_q;
    logic [3:0] code_q;
    logic       start;
    logic       run;
    half_t      half_val [NUM_GROUPS];
    logic       tone_bit [NUM_GROUPS];

    assign start = tone_en && !en_q;
    assign run   = tone_en && en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            code_q <= '0;
        end else begin
            en_q <= tone_en;
            if (start) begin
                code_q <= code;
            end
        end
    end

    dtmf_code_map map_i (
        .code_q       (code_q),
        .row_half_val (half_val[0]),
        .col_half_val (half_val[1])
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_div
        dtmf_divider div_i (
            .clk      (clk),
            .rst      (rst),
            .clear    (start),
            .run      (run),
            .half_val (half_val[g]),
            .tone     (tone_bit[g])
        );
    end

    assign low_tone  = tone_bit[0];
    assign high_tone = tone_bit[1];

    dtmf_summer #(
        .LOW_AMP  (LOW_AMP),
        .HIGH_AMP (HIGH_AMP),
        .SAMPLE_W (SAMPLE_W)
    ) sum_i (
        .clk       (clk),
        .rst       (rst),
        .low_tone  (low_tone),
        .high_tone (high_tone),
        .sample    (sample)
    );

    // R7: the stored code holds for the whole enabled interval
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (tone_en && en_q) |=> $stable(code_q));

    // R8: disabled means idle sample on the next edge
    assert_idle_sample_R8: assert property (@(posedge clk) disable iff (rst)
        !tone_en |=> (sample == IDLE_LEVEL));

    // R1: reset leaves both tones low
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!low_tone && !high_tone));

endmodule

// File: tb/dtmf_pair_gen_tb.sv
module dtmf_pair_gen_tb_top;

    localparam time CLK_PERIOD = 280ns;
    localparam int  WATCHDOG_CYCLES = 195000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tone_en = 1'b0;
    logic [3:0]        code = 4'd0;
    logic              low_tone;
    logic              high_tone;
    logic signed [7:0] sample;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dtmf_pair_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .tone_en   (tone_en),
        .code      (code),
        .low_tone  (low_tone),
        .high_tone (high_tone),
        .sample    (sample)
    );

    // full ratios listed by frequency, row then column
    function automatic int row_of(input int c);
        if (c == 0)  return 3;
        if (c >= 13) return c - 13;
        return (c - 1) / 3;
    endfunction

    function automatic int col_of(input int c);
        if (c == 0 || c >= 13) return 3;
        if (c == 10) return 1;
        if (c == 11) return 0;
        return (c - 1) % 3;
    endfunction

    function automatic int row_ratio(input int r);
        int t [4] = '{5104, 4640, 4176, 3828};
        return t[r];
    endfunction

    function automatic int col_ratio(input int k);
        int t [4] = '{2944, 2688, 2432, 2176};
        return t[k];
    endfunction

    function automatic int exp_sample(input bit lt, input bit ht);
        return (lt ? 48 : -48) + (ht ? 66 : -66);
    endfunction

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // one enabled interval starting at a fresh rising enable
    task automatic run_tone(input int c, input int len, input bit swap_code);
        int hl = row_ratio(row_of(c)) / 2;
        int hh = col_ratio(col_of(c)) / 2;
        int bad_l = 0, bad_h = 0, bad_s = 0, first_bad_l = -1, first_bad_h = -1;
        @(negedge clk);
        code    = 4'(c);
        tone_en = 1'b1;
        @(posedge clk);
        for (int n = 0; n < len; n++) begin
            bit el, eh;
            @(negedge clk);
            el = ((n / hl) % 2) == 1;
            eh = ((n / hh) % 2) == 1;
            if (low_tone !== el) begin bad_l++; if (first_bad_l < 0) first_bad_l = n; end
            if (high_tone !== eh) begin bad_h++; if (first_bad_h < 0) first_bad_h = n; end
            if (int'(sample) != exp_sample(low_tone, high_tone)) bad_s++;
            if (swap_code && n == len / 2) code = ~code;
        end
        check(bad_l == 0, $sformatf("R2 R4 R6 R7 low tone code %0d (bad cycles, first at %0d)", c, first_bad_l), bad_l, 0);
        check(bad_h == 0, $sformatf("R3 R5 R6 R7 high tone code %0d (bad cycles, first at %0d)", c, first_bad_h), bad_h, 0);
        check(bad_s == 0, $sformatf("R9 sample sum code %0d (bad cycles)", c), bad_s, 0);
    endtask

    task automatic idle_gap(input int len);
        int bad = 0;
        @(negedge clk);
        tone_en = 1'b0;
        code    = 4'($urandom_range(0, 15));
        for (int n = 0; n < len; n++) begin
            @(negedge clk);
            if (low_tone !== 1'b0 || high_tone !== 1'b0 || sample != -8'sd114) bad++;
        end
        check(bad == 0, "R8 idle while disabled (bad cycles)", bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20250));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(low_tone === 1'b0 && high_tone === 1'b0, "R1 tones in reset", {low_tone, high_tone}, 0);
        check(sample == -8'sd114, "R1 sample in reset", int'(sample), -114);
        rst = 1'b0;

        // directed: every code for more than one full row period
        for (int c = 0; c < 16; c++) begin
            run_tone(c, 5300, 1'b0);
            idle_gap(3);
        end

        // R7 directed: code flipped mid interval
        run_tone(5, 5300, 1'b1);
        idle_gap(1);

        // random runs, some with code changes, then reset mid run
        for (int i = 0; i < 10; i++) begin
            int c   = $urandom_range(0, 15);
            int len = $urandom_range(1000, 4500);
            run_tone(c, len, $urandom_range(0, 1) == 1);
            idle_gap($urandom_range(1, 40));
        end

        run_tone(7, 1500, 1'b0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(low_tone === 1'b0 && high_tone === 1'b0 && sample == -8'sd114,
              "R1 reset during tone", int'(sample), -114);
        rst = 1'b0;
        tone_en = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < WATCHDOG_CYCLES && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule